// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Sequencer

This block programs a 32K x 8 one-time-programmable memory with a pulse-and-verify algorithm. A single `start` pulse runs the whole flow. The sequencer first raises the programming core supply and then the high-voltage supply. It then works through two passes. The first pass gives every byte exactly one program pulse and reads nothing back. The second pass reads each byte back, and on a mismatch it gives the byte more pulses until the byte verifies or the retry budget runs out. After the second pass both supplies go back to nominal, and every byte is read once more and compared before the sequencer reports pass or fail.

The byte to be written comes from a combinational fetch port. The data presented on `fetch_data` must belong to the address currently on `mem_addr`. The memory's read data comes back on `rd_data`. All durations are whole numbers of microsecond ticks. A restartable divider makes these ticks from the clock, so every wait is an exact number of clock cycles.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset the block is idle. `mem_en_n`=1, `mem_rd_n`=1, `sup_core_hi`=0, `sup_hv_on`=0, `busy`=0 and `done`=0.
- R2: `sup_core_hi` rises at least SETUP_US µs before `sup_hv_on` rises. `sup_hv_on` falls at least SETUP_US µs before `sup_core_hi` falls. `sup_hv_on` is never 1 while `sup_core_hi` is 0. Both are 0 once `done` is set.
- R3: A program pulse holds `mem_en_n` low, with `mem_rd_n` high, for PULSE_US ticks. That is exactly PULSE_US*TICK_DIV+1 cycles, which lies inside the 95..105 µs window.
- R4: Before `mem_en_n` falls, the address and the `mem_rd_n`=1 level are stable for at least SETUP_US µs. After `mem_en_n` rises, the address (and so the data) is held for at least HOLD_US µs.
- R5: The first pass pulses every address exactly once, in ascending order from 0 to the last address, with no read in between.
- R6: The second pass reads with `mem_en_n`=1 and `mem_rd_n`=0. Each mismatch gives one further pulse followed by a re-read, at most MAX_RETRY extra pulses per byte. `retry_count` shows the extra pulses given to the current byte, and after a good pass it holds the value for the last address.
- R7: A byte that still mismatches after MAX_RETRY extra pulses aborts the flow. The supplies are lowered in order, and then `done`=1, `pass`=0, `fail_addr` is the byte's address and `retry_count`=MAX_RETRY. Later addresses receive no extra pulses, and there is no final read.
- R8: The final check reads every address in ascending order with both supplies at nominal, `mem_en_n`=0 and `mem_rd_n`=0. The first mismatch ends the flow with `pass`=0 and `fail_addr` set to that address. If every byte matches, the flow ends with `pass`=1.
- R9: `start` is ignored while `busy`=1.
- R10: `mem_wdata` always equals `fetch_data`. The fetch port is indexed by `mem_addr`.
- R11: `done`, `pass` and `fail_addr` stay unchanged after completion until the next `start`. `busy` is 0 whenever `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run (sampled while idle or finished) |
| fetch_data | input | DATA_W | Intended byte for `mem_addr` |
| rd_data | input | DATA_W | Data read back from the memory |
| mem_addr | output | ADDR_W | Memory address, also indexes the fetch port |
| mem_wdata | output | DATA_W | Data driven to the memory |
| mem_en_n | output | 1 | Active-low chip enable; low with `mem_rd_n` high is a program pulse |
| mem_rd_n | output | 1 | Active-low output enable |
| sup_core_hi | output | 1 | Selects the programming level of the core supply |
| sup_hv_on | output | 1 | Selects the high programming voltage |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The run has finished; results are valid |
| pass | output | 1 | The run succeeded |
| fail_addr | output | ADDR_W | Address that caused a failure |
| retry_count | output | RTY_W | Extra pulses given to the current or failing byte |

## Verification
The block's outputs change only on rising clock edges, so the bench samples them on falling edges. It measures each interval from the cycle counter at the moments the outputs switch. A pulse entered on one rising edge ends PULSE_US*TICK_DIV+1 cycles later, and the bench checks that width against the 95..105 µs window scaled by the divider. Setup and hold are checked the same way, as cycle differences of at least 2*TICK_DIV between an address or enable change and the next pulse edge. The status results (`done`, `pass`, `fail_addr`, `retry_count`) and the pulse counts for each address are read only in the first falling-edge sample where `done` is high, and again some cycles later to confirm they held.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CORE_UP,
        ST_HV_UP,
        ST_P1_SETUP,
        ST_P1_PULSE,
        ST_P1_HOLD,
        ST_V_SETUP,
        ST_V_READ,
        ST_R_SETUP,
        ST_R_PULSE,
        ST_R_HOLD,
        ST_HV_DN,
        ST_CORE_DN,
        ST_F_SETUP,
        ST_F_READ,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic en_n;
        logic rd_n;
        logic core_hi;
        logic hv_on;
    } pin_ctl_t;

    function automatic pin_ctl_t state_pins(seq_state_e s);
        pin_ctl_t p;
        p.en_n    = !(s inside {ST_P1_PULSE, ST_R_PULSE, ST_F_READ});
        p.rd_n    = !(s inside {ST_V_READ, ST_F_READ});
        p.core_hi = s inside {ST_CORE_UP, ST_HV_UP, ST_P1_SETUP, ST_P1_PULSE,
                              ST_P1_HOLD, ST_V_SETUP, ST_V_READ, ST_R_SETUP,
                              ST_R_PULSE, ST_R_HOLD, ST_HV_DN};
        p.hv_on   = s inside {ST_HV_UP, ST_P1_SETUP, ST_P1_PULSE, ST_P1_HOLD,
                              ST_V_SETUP, ST_V_READ, ST_R_SETUP, ST_R_PULSE,
                              ST_R_HOLD};
        return p;
    endfunction

    function automatic logic is_active(seq_state_e s);
        return (s != ST_IDLE) && (s != ST_FINISH);
    endfunction

endpackage

// File: rtl/otp_tick_gen.sv
module otp_tick_gen #(
    parameter int unsigned TICK_DIV = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] div_q;

    assign tick = (div_q == CW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/otp_tick_timer.sv
module otp_tick_timer #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)                     cnt_q <= '0;
        else if (load)               cnt_q <= load_val;
        else if (tick && !expired)   cnt_q <= cnt_q - 1'b1;
    end

    // a fresh load never reports expiry in the cycle that follows it
    AST_LOAD_NOT_EXPIRED: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !expired);  // R3
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned TICK_DIV  = 125,
    parameter int unsigned PULSE_US  = 100,
    parameter int unsigned SETUP_US  = 2,
    parameter int unsigned HOLD_US   = 2,
    parameter int unsigned READ_US   = 1,
    parameter int unsigned MAX_RETRY = 10,
    localparam int unsigned RTY_W    = $clog2(MAX_RETRY + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] fetch_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_en_n,
    output logic              mem_rd_n,
    output logic              sup_core_hi,
    output logic              sup_hv_on,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [RTY_W-1:0]  retry_count
);
    localparam int unsigned MAX_A   = (PULSE_US > SETUP_US) ? PULSE_US : SETUP_US;
    localparam int unsigned MAX_B   = (HOLD_US > READ_US) ? HOLD_US : READ_US;
    localparam int unsigned MAX_DUR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned TMR_W   = $clog2(MAX_DUR + 1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [RTY_W-1:0]  retry_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic              done_q, pass_q, abort_q;
    logic              tick, tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              byte_ok, at_last, retry_spent;
    pin_ctl_t          pins;

    function automatic logic [TMR_W-1:0] dur_of(seq_state_e s);
        case (s)
            ST_P1_PULSE, ST_R_PULSE: return TMR_W'(PULSE_US);
            ST_P1_HOLD,  ST_R_HOLD:  return TMR_W'(HOLD_US);
            ST_V_READ,   ST_F_READ:  return TMR_W'(READ_US);
            default:                 return TMR_W'(SETUP_US);
        endcase
    endfunction

    otp_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk(clk), .rst(rst), .clr(tmr_load), .tick(tick)
    );

    otp_tick_timer #(.CNT_W(TMR_W)) tmr_i (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .tick(tick), .expired(tmr_exp)
    );

    assign byte_ok     = (rd_data == fetch_data);
    assign at_last     = (addr_q == {ADDR_W{1'b1}});
    assign retry_spent = (retry_q == RTY_W'(MAX_RETRY));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: if (start) state_d = ST_CORE_UP;
            ST_CORE_UP:  if (tmr_exp) state_d = ST_HV_UP;
            ST_HV_UP:    if (tmr_exp) state_d = ST_P1_SETUP;
            ST_P1_SETUP: if (tmr_exp) state_d = ST_P1_PULSE;
            ST_P1_PULSE: if (tmr_exp) state_d = ST_P1_HOLD;
            ST_P1_HOLD:  if (tmr_exp) state_d = at_last ? ST_V_SETUP : ST_P1_SETUP;
            ST_V_SETUP:  if (tmr_exp) state_d = ST_V_READ;
            ST_V_READ:
                if (tmr_exp) begin
                    if (byte_ok)          state_d = at_last ? ST_HV_DN : ST_V_SETUP;
                    else if (retry_spent) state_d = ST_HV_DN;
                    else                  state_d = ST_R_SETUP;
                end
            ST_R_SETUP:  if (tmr_exp) state_d = ST_R_PULSE;
            ST_R_PULSE:  if (tmr_exp) state_d = ST_R_HOLD;
            ST_R_HOLD:   if (tmr_exp) state_d = ST_V_READ;
            ST_HV_DN:    if (tmr_exp) state_d = ST_CORE_DN;
            ST_CORE_DN:  if (tmr_exp) state_d = abort_q ? ST_FINISH : ST_F_SETUP;
            ST_F_SETUP:  if (tmr_exp) state_d = ST_F_READ;
            ST_F_READ:
                if (tmr_exp) state_d = (!byte_ok || at_last) ? ST_FINISH : ST_F_SETUP;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_d != state_q);
    assign tmr_val  = dur_of(state_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            retry_q     <= '0;
            fail_addr_q <= '0;
            done_q      <= 1'b0;
            pass_q      <= 1'b0;
            abort_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE, ST_FINISH:
                    if (start) begin
                        addr_q      <= '0;
                        retry_q     <= '0;
                        fail_addr_q <= '0;
                        done_q      <= 1'b0;
                        pass_q      <= 1'b0;
                        abort_q     <= 1'b0;
                    end
                ST_P1_HOLD:
                    if (tmr_exp) addr_q <= addr_q + 1'b1;
                ST_V_READ:
                    if (tmr_exp) begin
                        if (byte_ok) begin
                            addr_q <= addr_q + 1'b1;
                            if (!at_last) retry_q <= '0;
                        end else if (retry_spent) begin
                            abort_q     <= 1'b1;
                            fail_addr_q <= addr_q;
                        end
                    end
                ST_R_SETUP:
                    if (tmr_exp) retry_q <= retry_q + 1'b1;
                ST_CORE_DN:
                    if (tmr_exp && abort_q) done_q <= 1'b1;
                ST_F_READ:
                    if (tmr_exp) begin
                        if (!byte_ok) begin
                            fail_addr_q <= addr_q;
                            done_q      <= 1'b1;
                        end else if (at_last) begin
                            done_q <= 1'b1;
                            pass_q <= 1'b1;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                default: ;
            endcase
        end
    end

    assign pins        = state_pins(state_q);
    assign mem_en_n    = pins.en_n;
    assign mem_rd_n    = pins.rd_n;
    assign sup_core_hi = pins.core_hi;
    assign sup_hv_on   = pins.hv_on;
    assign mem_addr    = addr_q;
    assign mem_wdata   = fetch_data;
    assign busy        = is_active(state_q);
    assign done        = done_q;
    assign pass        = pass_q;
    assign fail_addr   = fail_addr_q;
    assign retry_count = retry_q;

    AST_HV_NEEDS_CORE: assert property (@(posedge clk) disable iff (rst)
        sup_hv_on |-> sup_core_hi);  // R2
    AST_PULSE_RD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!mem_en_n && sup_hv_on) |-> mem_rd_n);  // R3
    AST_ADDR_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!mem_en_n && !$past(mem_en_n)) |-> $stable(mem_addr));  // R4
    AST_VERIFY_EN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n && sup_hv_on) |-> mem_en_n);  // R6
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        retry_count <= RTY_W'(MAX_RETRY));  // R6
    AST_FINAL_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        (!mem_en_n && !mem_rd_n) |-> (!sup_hv_on && !sup_core_hi));  // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);  // R11
    AST_DONE_SUPPLIES_LOW: assert property (@(posedge clk) disable iff (rst)
        done |-> (!sup_hv_on && !sup_core_hi));  // R2
endmodule

// File: tb/otp_prog_seq_tb_top.sv
module otp_prog_seq_tb_top;
    localparam int AW   = 4;
    localparam int N    = 1 << AW;
    localparam int DIV  = 2;
    localparam int PUL  = 100;
    localparam int SET  = 2;
    localparam int HLD  = 2;
    localparam int MAXR = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] fetch_data, rd_data, mem_wdata;
    logic [AW-1:0] mem_addr, fail_addr;
    logic mem_en_n, mem_rd_n, sup_core_hi, sup_hv_on, busy, done, pass;
    logic [3:0] retry_count;

    always #4 clk = ~clk;

    otp_prog_seq #(.ADDR_W(AW), .DATA_W(8), .TICK_DIV(DIV), .PULSE_US(PUL),
                   .SETUP_US(SET), .HOLD_US(HLD), .READ_US(1), .MAX_RETRY(MAXR)) dut_i (
        .clk(clk), .rst(rst), .start(start), .fetch_data(fetch_data), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_en_n(mem_en_n), .mem_rd_n(mem_rd_n),
        .sup_core_hi(sup_core_hi), .sup_hv_on(sup_hv_on), .busy(busy), .done(done),
        .pass(pass), .fail_addr(fail_addr), .retry_count(retry_count)
    );

    int checks = 0;
    int errors = 0;
    int need [N];
    int pulses [N];
    int corrupt = -1;
    int cyc = 0;
    bit wd_hit = 1'b0;
    bit mon_clr = 1'b0;

    function automatic logic [7:0] tgt(input int a);
        return 8'((a * 29 + 90) ^ 60);
    endfunction

    assign fetch_data = tgt(int'(mem_addr));

    always_comb begin
        logic good;
        good = pulses[mem_addr] >= need[mem_addr];
        if (!sup_core_hi && int'(mem_addr) == corrupt) good = 1'b0;
        rd_data = good ? tgt(int'(mem_addr)) : ~tgt(int'(mem_addr));
    end

    // monitor state, sampled on falling edges
    int total, fread, width_err, setup_err, hold_err, order_err, supply_err, wdata_err;
    int core_up_c, hv_up_c, hv_dn_c, core_dn_c, up_lead, dn_lead;
    int pw_start, addr_chg_c, rd_high_c, hold_start;
    bit hold_act;
    logic p_en, p_rd, p_core, p_hv;
    logic [AW-1:0] p_addr;

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            foreach (pulses[i]) pulses[i] = 0;
            total = 0; fread = 0; width_err = 0; setup_err = 0; hold_err = 0;
            order_err = 0; supply_err = 0; wdata_err = 0;
            up_lead = 0; dn_lead = 0; hold_act = 1'b0;
            addr_chg_c = cyc; rd_high_c = cyc;
        end else if (!rst) begin
            if (sup_hv_on && !sup_core_hi) supply_err++;
            if (mem_wdata !== tgt(int'(mem_addr))) wdata_err++;
            if (sup_core_hi && !p_core) core_up_c = cyc;
            if (sup_hv_on && !p_hv) begin hv_up_c = cyc; up_lead = hv_up_c - core_up_c; end
            if (!sup_hv_on && p_hv) hv_dn_c = cyc;
            if (!sup_core_hi && p_core) begin core_dn_c = cyc; dn_lead = core_dn_c - hv_dn_c; end
            if (mem_addr != p_addr) begin
                if (hold_act && (cyc - hold_start) < HLD * DIV) hold_err++;
                hold_act = 1'b0;
                addr_chg_c = cyc;
            end
            if (mem_rd_n && !p_rd) rd_high_c = cyc;
            if (!mem_rd_n && p_rd && sup_hv_on && total < N) order_err++;
            if (!mem_en_n && p_en) begin
                if (sup_hv_on) begin
                    pw_start = cyc;
                    if ((cyc - addr_chg_c) < SET * DIV || (cyc - rd_high_c) < SET * DIV)
                        setup_err++;
                end else if (!sup_core_hi) fread++;
            end
            if (mem_en_n && !p_en && sup_hv_on) begin
                if ((cyc - pw_start) < 95 * DIV || (cyc - pw_start) > 105 * DIV) width_err++;
                if (total < N && int'(mem_addr) != total) order_err++;
                pulses[mem_addr]++;
                total++;
                hold_start = cyc;
                hold_act = 1'b1;
            end
        end
        p_en = mem_en_n; p_rd = mem_rd_n; p_core = sup_core_hi; p_hv = sup_hv_on;
        p_addr = mem_addr;
        if (cyc > 190000) wd_hit = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input bit poke_start);
        int abort_at, exp_tot, bad_cnt, exp_fr, exp_ret;
        int exp_p [N];
        bit exp_pass;
        abort_at = -1;
        for (int a = 0; a < N; a++)
            if (abort_at < 0 && need[a] > MAXR + 1) abort_at = a;
        exp_tot = 0;
        for (int a = 0; a < N; a++) begin
            if (abort_at < 0 || a < abort_at) exp_p[a] = need[a];
            else if (a == abort_at)           exp_p[a] = MAXR + 1;
            else                              exp_p[a] = 1;
            exp_tot += exp_p[a];
        end
        exp_pass = (abort_at < 0) && (corrupt < 0);
        exp_ret  = (abort_at >= 0) ? MAXR : need[N-1] - 1;
        exp_fr   = (abort_at >= 0) ? 0 : ((corrupt >= 0) ? corrupt + 1 : N);

        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_start) begin
            repeat (600) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9 busy after ignored start", int'(busy), 1);
        end
        while (!done && !wd_hit) @(negedge clk);
        if (wd_hit) begin
            chk(1'b0, "watchdog", 0, 1);
            return;
        end
        chk(pass == exp_pass, "R8 pass", int'(pass), int'(exp_pass));
        if (abort_at >= 0)
            chk(int'(fail_addr) == abort_at, "R7 fail_addr", int'(fail_addr), abort_at);
        else if (corrupt >= 0)
            chk(int'(fail_addr) == corrupt, "R8 fail_addr", int'(fail_addr), corrupt);
        chk(int'(retry_count) == exp_ret, "R6 R7 retry_count", int'(retry_count), exp_ret);
        bad_cnt = 0;
        for (int a = 0; a < N; a++) if (pulses[a] != exp_p[a]) bad_cnt++;
        chk(bad_cnt == 0, "R6 R7 per-address pulse counts", bad_cnt, 0);
        chk(total == exp_tot, "R5 R9 total pulses", total, exp_tot);
        chk(fread == exp_fr, "R8 final reads", fread, exp_fr);
        chk(width_err == 0, "R3 pulse width", width_err, 0);
        chk(setup_err == 0 && hold_err == 0, "R4 setup/hold", setup_err + hold_err, 0);
        chk(order_err == 0, "R5 first pass order", order_err, 0);
        chk(supply_err == 0, "R2 hv without core", supply_err, 0);
        chk(up_lead >= SET * DIV, "R2 power-up lead", up_lead, SET * DIV);
        chk(dn_lead >= SET * DIV, "R2 power-down lead", dn_lead, SET * DIV);
        chk(!sup_core_hi && !sup_hv_on, "R2 supplies low at done",
            int'(sup_core_hi) + int'(sup_hv_on), 0);
        chk(wdata_err == 0, "R10 write data", wdata_err, 0);
        repeat (7) @(negedge clk);
        chk(done && !busy && pass == exp_pass, "R11 result held", int'(done), 1);
    endtask

    task automatic set_need_all(input int v);
        for (int a = 0; a < N; a++) need[a] = v;
        corrupt = -1;
    endtask

    task automatic set_need_rand();
        set_need_all(1);
        for (int k = 0; k < 5; k++) need[$urandom_range(N - 1, 0)] = 1 + int'($urandom_range(MAXR, 0));
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4711);
        set_need_all(1);
        foreach (pulses[i]) pulses[i] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 idle state
        chk(mem_en_n && mem_rd_n && !sup_core_hi && !sup_hv_on && !busy && !done,
            "R1 reset state", {mem_en_n, mem_rd_n, sup_core_hi, sup_hv_on, busy, done}, 6'b110000);

        set_need_all(1);              run_case(1'b0);   // R5 one pulse each
        set_need_rand();              run_case(1'b0);   // R6 random retries
        set_need_rand();              run_case(1'b0);
        set_need_all(1); need[5] = MAXR + 1; need[N-1] = 3;
                                      run_case(1'b0);   // R6 limit reached but verifies
        set_need_all(1); need[2] = 4; need[6] = MAXR + 2;
                                      run_case(1'b0);   // R7 abort
        set_need_all(1); need[3] = 2; corrupt = 9;
                                      run_case(1'b0);   // R8 final mismatch
        set_need_rand();              run_case(1'b1);   // R9 start while busy

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule